// File: doc/BRIEF.md
# Mailbox Event Flag Bank

This block keeps the per-mailbox status flags of a sixteen-mailbox CAN controller. There are four flag words: receive done, unread message lost, transmit acknowledged and abort acknowledged. There is also one flag for a transmitted overload frame. The message engine reports each event as a single-cycle pulse with a mailbox index. Software reads the flags over a plain 16-bit register port and clears any flag by writing a 1 to its bit. A single interrupt line goes high while any flag that is not masked is set.

The event channels carry valid only, with no ready. The block accepts every pulse in the cycle it arrives, so the engine never sees back-pressure. One pulse of each of the three kinds can arrive in the same clock. In every register word the two bytes hold the mailboxes in swapped order: bits 15..8 hold mailboxes 7..0 and bits 7..0 hold mailboxes 15..8. Register offsets are 0 for receive done, 1 for unread lost, 2 for transmit acknowledged, 3 for abort acknowledged, 4 for the mask and 5 for the overload word. In the overload word, bit 0 is the flag and bit 1 is its mask.

Top module: `mbx_status_bank`

## Requirements
- R1: After reset every flag reads 0, the mask word at offset 4 reads 0xFFFF, offset 5 reads 0x0002 and `irq` is low.
- R2: A receive pulse (`evt_valid[0]`, index in `evt_idx[3:0]`) sets that mailbox's receive-done flag after the clock edge. Mailbox m<8 appears at register bit 8+m and mailbox m>=8 at bit m-8.
- R3: Writing a word to a flag offset clears each flag whose bit is 1. Flags whose bit is 0 keep their value.
- R4: If a set pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R5: A receive pulse for a mailbox whose receive-done flag is already 1 at that edge sets its unread-lost flag. The flag is set even when the same cycle clears receive-done. A receive pulse for a mailbox whose receive-done flag is 0 leaves unread-lost unchanged.
- R6: A transmit-ack pulse (`evt_valid[1]`, `evt_idx[7:4]`) sets the transmit-acknowledged flag. An abort pulse (`evt_valid[2]`, `evt_idx[11:8]`) sets the abort-acknowledged flag.
- R7: Mailbox 0 has no transmit-acknowledged or abort-acknowledged flag. Register bit 8 at offsets 2 and 3 always reads 0, and pulses or writes aimed at it have no effect.
- R8: `ovl_pulse` sets bit 0 of offset 5. Writing 1 to that bit clears it, and a pulse in the same cycle wins over the clear. Bit 1 of offset 5 is read/write.
- R9: `irq` is high exactly when some flag is set and its mask bit is 0. The mask bit for a mailbox sits at the same position as that mailbox's flag bit, and it gates the mailbox in all four flag words. Bit 1 of offset 5 masks the overload flag.
- R10: Offsets 6 and 7 read 0, and writes to them change nothing.
- R11: Pulses of all three kinds and a register write in one cycle each take effect, without interfering with one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 3 | Event pulses: bit 0 receive, bit 1 transmit ack, bit 2 abort ack |
| evt_idx | input | 12 | Mailbox index per event kind, 4 bits each, kind 0 in the low nibble |
| ovl_pulse | input | 1 | Overload frame transmitted |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the word at `addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each pulse lasts one cycle and carries an index in the range 0 to 15. They also assume that at most one pulse of each kind arrives per clock, so a second pulse of the same kind never competes with the first. The stimulus has one valid bit and one index field per kind, which makes a same-kind collision impossible. Every index is drawn from the full 4-bit range. Random cycles mix all three kinds, overload pulses and writes to every offset, including the unused ones. Directed cases aim set/clear collisions and repeat receptions at chosen mailboxes.

// File: rtl/mbx_flag_pkg.sv
package mbx_flag_pkg;
  // event kind position within evt_valid / evt_idx
  typedef enum int unsigned {
    EV_RX = 0,
    EV_TX = 1,
    EV_AB = 2
  } evt_kind_e;

  localparam int unsigned EV_N = 3;

  // register word offsets
  localparam int unsigned OFF_RX  = 0;
  localparam int unsigned OFF_UR  = 1;
  localparam int unsigned OFF_TX  = 2;
  localparam int unsigned OFF_AB  = 3;
  localparam int unsigned OFF_MSK = 4;
  localparam int unsigned OFF_OVL = 5;
endpackage

// File: rtl/mbx_idx_decode.sv
module mbx_idx_decode #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          valid,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  hot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = valid && (idx == IW'(i));
  end
endmodule

// File: rtl/mbx_w1c_bank.sv
module mbx_w1c_bank #(
  parameter int         N   = 16,
  parameter logic [N-1:0] RSV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    if (RSV[i]) begin : g_rsv
      assign q[i] = 1'b0;
    end else begin : g_ff
      logic f;
      always_ff @(posedge clk) begin
        if (!rst_n) f <= 1'b0;
        else        f <= set[i] | (f & ~clr[i]);
      end
      assign q[i] = f;
    end
  end
endmodule

// File: rtl/mbx_status_bank.sv
module mbx_status_bank
  import mbx_flag_pkg::*;
#(
  parameter int MBOX_N = 16,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            evt_valid,
  input  logic [3*IDX_W-1:0]    evt_idx,
  input  logic                  ovl_pulse,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [MBOX_N-1:0]     wdata,
  output logic [MBOX_N-1:0]     rdata,
  output logic                  irq
);
  localparam int HALF = MBOX_N / 2;
  localparam logic [MBOX_N-1:0] RSV0 = MBOX_N'(1);

  // decoded events, one row per kind
  logic [MBOX_N-1:0] ev_hot [EV_N];
  for (genvar k = 0; k < int'(EV_N); k++) begin : g_dec
    mbx_idx_decode #(.N(MBOX_N), .IW(IDX_W)) u_dec (
      .valid (evt_valid[k]),
      .idx   (evt_idx[k*IDX_W +: IDX_W]),
      .hot   (ev_hot[k])
    );
  end

  // register byte lanes hold mailboxes in swapped order
  logic [MBOX_N-1:0] wd_mb;
  assign wd_mb = {wdata[HALF-1:0], wdata[MBOX_N-1:HALF]};

  function automatic logic [MBOX_N-1:0] to_reg(input logic [MBOX_N-1:0] mb);
    return {mb[HALF-1:0], mb[MBOX_N-1:HALF]};
  endfunction

  function automatic logic [MBOX_N-1:0] clr_for(input int unsigned off);
    return (wr_en && addr == ADDR_W'(off)) ? wd_mb : '0;
  endfunction

  logic [MBOX_N-1:0] rx_q, ur_q, tx_q, ab_q, mask_q;
  logic              ovl_q, ovl_msk_q;

  mbx_w1c_bank #(.N(MBOX_N)) u_rx (
    .clk(clk), .rst_n(rst_n), .set(ev_hot[EV_RX]), .clr(clr_for(OFF_RX)), .q(rx_q));

  // overwrite detection uses the flag value held before this edge
  mbx_w1c_bank #(.N(MBOX_N)) u_ur (
    .clk(clk), .rst_n(rst_n), .set(ev_hot[EV_RX] & rx_q), .clr(clr_for(OFF_UR)), .q(ur_q));

  mbx_w1c_bank #(.N(MBOX_N), .RSV(RSV0)) u_tx (
    .clk(clk), .rst_n(rst_n), .set(ev_hot[EV_TX]), .clr(clr_for(OFF_TX)), .q(tx_q));

  mbx_w1c_bank #(.N(MBOX_N), .RSV(RSV0)) u_ab (
    .clk(clk), .rst_n(rst_n), .set(ev_hot[EV_AB]), .clr(clr_for(OFF_AB)), .q(ab_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      ovl_q     <= 1'b0;
      ovl_msk_q <= 1'b1;
    end else begin
      if (wr_en && addr == ADDR_W'(OFF_MSK)) mask_q <= wd_mb;
      if (wr_en && addr == ADDR_W'(OFF_OVL)) ovl_msk_q <= wdata[1];
      ovl_q <= ovl_pulse | (ovl_q & ~(wr_en && addr == ADDR_W'(OFF_OVL) && wdata[0]));
    end
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      OFF_RX:  rdata = to_reg(rx_q);
      OFF_UR:  rdata = to_reg(ur_q);
      OFF_TX:  rdata = to_reg(tx_q);
      OFF_AB:  rdata = to_reg(ab_q);
      OFF_MSK: rdata = to_reg(mask_q);
      OFF_OVL: rdata = MBOX_N'({ovl_msk_q, ovl_q});
      default: rdata = '0;
    endcase
  end

  assign irq = (|((rx_q | ur_q | tx_q | ab_q) & ~mask_q)) | (ovl_q & ~ovl_msk_q);
endmodule

// File: rtl/mbx_status_bank_chk.sv
module mbx_status_bank_chk
  import mbx_flag_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    evt_valid,
  input logic [3*IW-1:0] evt_idx,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [N-1:0]  wdata,
  input logic          irq,
  input logic [N-1:0]  rx_q,
  input logic [N-1:0]  ur_q,
  input logic [N-1:0]  tx_q,
  input logic [N-1:0]  ab_q,
  input logic [N-1:0]  mask_q,
  input logic          ovl_msk_q
);
  localparam int H = N / 2;
  logic [N-1:0] wd_mb;
  assign wd_mb = {wdata[H-1:0], wdata[N-1:H]};

  // R2: receive pulse lands in its mailbox flag
  a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid[0] |=> rx_q[$past(evt_idx[IW-1:0])]);

  // R5: repeat reception before clear marks the message lost
  a_r5_unread_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid[0] && rx_q[evt_idx[IW-1:0]]) |=> ur_q[$past(evt_idx[IW-1:0])]);

  // R6: transmit ack to a real mailbox sets its flag
  a_r6_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid[1] && evt_idx[2*IW-1:IW] != '0) |=> tx_q[$past(evt_idx[2*IW-1:IW])]);

  // R9: everything masked keeps the request low
  a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q && ovl_msk_q) |-> !irq);

  for (genvar m = 0; m < N; m++) begin : g_mb
    // R3: write-one clears when no set competes
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(OFF_RX) && wd_mb[m] && !(evt_valid[0] && evt_idx[IW-1:0] == IW'(m)))
      |=> !rx_q[m]);
    // R3: a set flag only drops after a write-one
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_q[m] && !(wr_en && addr == AW'(OFF_AB) && wd_mb[m])) |=> ab_q[m]);
    // R5: lost flag only rises on a repeat reception
    a_r5_unread_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ur_q[m]) |-> $past(evt_valid[0] && evt_idx[IW-1:0] == IW'(m) && rx_q[m]));
  end
endmodule

bind mbx_status_bank mbx_status_bank_chk #(.N(MBOX_N), .IW(IDX_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .rx_q(rx_q), .ur_q(ur_q), .tx_q(tx_q), .ab_q(ab_q),
  .mask_q(mask_q), .ovl_msk_q(ovl_msk_q)
);

// File: tb/sim_mbx_status_bank.sv
module sim_mbx_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  evt_valid = '0;
  logic [11:0] evt_idx = '0;
  logic        ovl_pulse = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int vecs = 0;
  int errs = 0;

  // bench model, mailbox order
  logic [15:0] m_rx = '0, m_ur = '0, m_tx = '0, m_ab = '0, m_mask = '1;
  logic        m_ovl = 1'b0, m_ovm = 1'b1;

  always #4 clk = ~clk;

  mbx_status_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
    .ovl_pulse(ovl_pulse), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  function automatic logic [15:0] bswap(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    case (a)
      0: return bswap(m_rx);
      1: return bswap(m_ur);
      2: return bswap(m_tx);
      3: return bswap(m_ab);
      4: return bswap(m_mask);
      5: return {14'd0, m_ovm, m_ovl};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step();
    logic [15:0] c0, c1, c2, c3, s0, s1, s2;
    c0 = (wr_en && addr == 3'd0) ? bswap(wdata) : '0;
    c1 = (wr_en && addr == 3'd1) ? bswap(wdata) : '0;
    c2 = (wr_en && addr == 3'd2) ? bswap(wdata) : '0;
    c3 = (wr_en && addr == 3'd3) ? bswap(wdata) : '0;
    s0 = evt_valid[0] ? (16'd1 << evt_idx[3:0]) : '0;
    s1 = evt_valid[1] ? (16'd1 << evt_idx[7:4]) : '0;
    s2 = evt_valid[2] ? (16'd1 << evt_idx[11:8]) : '0;
    m_ur = (m_ur & ~c1) | (s0 & m_rx);
    m_rx = (m_rx & ~c0) | s0;
    m_tx = ((m_tx & ~c2) | s1) & 16'hFFFE;
    m_ab = ((m_ab & ~c3) | s2) & 16'hFFFE;
    if (wr_en && addr == 3'd4) m_mask = bswap(wdata);
    m_ovl = ovl_pulse | (m_ovl & ~(wr_en && addr == 3'd5 && wdata[0]));
    if (wr_en && addr == 3'd5) m_ovm = wdata[1];
  endtask

  // one clock: drive at negedge, model at posedge, return idle
  task automatic cyc(input logic [2:0] v, input logic [3:0] i0, input logic [3:0] i1,
                     input logic [3:0] i2, input logic ov, input logic we,
                     input logic [2:0] a, input logic [15:0] wd);
    evt_valid = v; evt_idx = {i2, i1, i0}; ovl_pulse = ov;
    wr_en = we; addr = a; wdata = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    evt_valid = '0; ovl_pulse = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic check_all(input string req);
    logic exp_irq;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      vecs++;
      if (rdata !== exp_read(a)) begin
        errs++;
        $display("FAIL %s offset %0d: got %h expected %h", req, a, rdata, exp_read(a));
      end
    end
    exp_irq = (|((m_rx | m_ur | m_tx | m_ab) & ~m_mask)) | (m_ovl & ~m_ovm);
    vecs++;
    if (irq !== exp_irq) begin
      errs++;
      $display("FAIL %s irq: got %b expected %b", req, irq, exp_irq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2: receive into mailboxes 3 and 12, swapped lanes
    cyc(3'b001, 4'd3, 4'd0, 4'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    cyc(3'b001, 4'd12, 4'd0, 4'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    check_all("R2");

    // R3: zeros change nothing, then clear mailbox 3 (bit 11)
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd0, 16'h0000);
    check_all("R3");
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd0, 16'h0800);
    check_all("R3");

    // R5: repeat on 12 marks lost, fresh on 5 does not
    cyc(3'b001, 4'd12, 4'd0, 4'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    cyc(3'b001, 4'd5, 4'd0, 4'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    check_all("R5");

    // R4: clear and set of mailbox 12 (bit 4) together, set wins
    cyc(3'b001, 4'd12, 4'd0, 4'd0, 1'b0, 1'b1, 3'd0, 16'h0010);
    check_all("R4");

    // R6 / R7: mailbox 0 reserved in ack words
    cyc(3'b110, 4'd0, 4'd9, 4'd0, 1'b0, 1'b0, 3'd0, 16'h0);
    cyc(3'b110, 4'd0, 4'd0, 4'd1, 1'b0, 1'b0, 3'd0, 16'h0);
    check_all("R6");
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd2, 16'h0100);
    check_all("R7");

    // R8: overload flag set, collision, clear
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b1, 1'b0, 3'd0, 16'h0);
    check_all("R8");
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b1, 1'b1, 3'd5, 16'h0003);
    check_all("R8");
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd5, 16'h0001);
    check_all("R8");

    // R9: unmask mailbox 9 only (bit 1), then everything
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd4, 16'hFFFD);
    check_all("R9");
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd2, 16'h0002);
    check_all("R9");
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd4, 16'h0000);
    check_all("R9");

    // R10: unused offsets
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd6, 16'hFFFF);
    cyc(3'b000, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 3'd7, 16'hFFFF);
    check_all("R10");

    // R11: mixed random traffic
    for (int n = 0; n < 400; n++) begin
      cyc(3'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
          ($urandom % 8) == 0, ($urandom % 3) == 0, 3'($urandom), 16'($urandom));
      check_all("R11");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule